// File: doc/BRIEF.md
# Reloadable Down-Counter Pulse Generator

This block is an 8-bit down-counting timer. A reload register supplies the start value, and a fixed divide-by-N prescaler sets the counting rate. The counter loses one unit on every prescaler tick. On the tick after it has reached zero it underflows: it reloads from the reload register and raises a sticky underflow request. In pulse mode each underflow also inverts a generated output level. Every edge of that output that matches the selected polarity raises a second sticky request. Each request drives an interrupt line through its own enable bit.

Software controls the block through a single-cycle write port. The port reaches three locations: the reload value, a control byte (halt, mode, polarity, the two enables) and the request flags, which are cleared by writing zero. The `slow_sel_i` input selects the count source. When it is low, the prescaler counts every clock cycle. When it is high, the prescaler counts only cycles in which the secondary-clock strobe `sub_tick_i` is high.

Top module: `pulse_timer`

## Requirements
- R1: After reset the counter and reload register hold all ones, the halt bit is 0, both flags, both interrupt lines and `pulse_o` are 0, and counting starts by itself: the counter reads 0xFE after exactly PRESCALE clock cycles.
- R2: While running, the counter drops by exactly 1 once every PRESCALE enabled cycles. A control write that changes halt from 1 to 0 restarts the prescaler from zero, so the first decrement comes PRESCALE cycles after that write.
- R3: With `slow_sel_i` high, only cycles with `sub_tick_i` high advance the prescaler; with `sub_tick_i` held low the counter does not move.
- R4: Underflow occurs on the tick after the counter reads 0x00, never on the tick that brings it to 0x00. At underflow the counter is loaded from the reload register, which gives an underflow period of (L+1)*PRESCALE enabled cycles for reload value L.
- R5: A write to address 0 (reload) stores the value; while halted it also loads the counter at once, and while running it leaves the counter untouched.
- R6: In pulse mode (control bits [2:1] = 01) `pulse_o` inverts on every underflow; in timer mode (bits [2:1] = 00) it holds its level.
- R7: A control write that switches the mode into pulse mode from another mode sets `pulse_o` to its starting level: high when the polarity bit (control bit 3) is 0, low when it is 1.
- R8: Each underflow sets the underflow flag; `uf_irq_o` is high exactly when that flag and the underflow enable (control bit 4) are both 1.
- R9: In pulse mode an active edge of `pulse_o` sets the edge flag: a falling edge when control bit 3 is 0, a rising edge when it is 1. `edge_irq_o` is that flag ANDed with control bit 5. In timer mode the edge flag is never set.
- R10: A write to address 2 clears the underflow flag where data bit 0 is 0 and the edge flag where data bit 1 is 0; a 1 in either bit leaves that flag as it is. A flag being set in the same cycle wins over a clear.
- R11: With control bit 0 (halt) at 1, the counter, the prescaler and `pulse_o` keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| slow_sel_i | input | 1 | Selects the secondary-clock strobe as the count source |
| sub_tick_i | input | 1 | Secondary-clock strobe, one cycle per secondary clock period |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | 0 reload, 1 control, 2 flags, 3 unused |
| wr_data_i | input | CNT_W | Write data |
| count_o | output | CNT_W | Current counter value |
| pulse_o | output | 1 | Generated pulse level |
| uf_flag_o | output | 1 | Underflow request flag |
| edge_flag_o | output | 1 | Pulse-edge request flag |
| uf_irq_o | output | 1 | Gated underflow interrupt |
| edge_irq_o | output | 1 | Gated pulse-edge interrupt |

## Verification
The bench builds the block with PRESCALE = 4 and the default 8-bit counter. With that setting a full reload period at the largest value, 255, takes only about a thousand cycles. Each sweep can therefore step through every cycle of two complete periods for reload values 0, 1, 3 and 255. Counter value, pulse level and flags are predicted from the cycle index by integer division. A strobed secondary clock, a halt window and a reload write in the middle of a run are covered at the same scale.

// File: rtl/ptmr_pkg.sv
package ptmr_pkg;

    typedef enum logic [1:0] {
        MODE_TIMER = 2'b00,
        MODE_PULSE = 2'b01,
        MODE_RSV2  = 2'b10,
        MODE_RSV3  = 2'b11
    } mode_e;

    typedef enum logic [1:0] {
        ADDR_RELOAD = 2'd0,
        ADDR_CTRL   = 2'd1,
        ADDR_FLAGS  = 2'd2,
        ADDR_NONE   = 2'd3
    } addr_e;

    // Control byte, msb first: bit5 edge enable, bit4 underflow enable,
    // bit3 polarity, bits2:1 mode, bit0 halt.
    typedef struct packed {
        logic  edge_irq_en;
        logic  uf_irq_en;
        logic  rise_sel;
        mode_e mode;
        logic  halt;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);

    // Starting level: high for falling-edge polarity, low for rising.
    function automatic logic start_level(input logic rise_sel);
        return !rise_sel;
    endfunction

    // A toggle from cur_level is the active edge when it moves toward the
    // level chosen by the polarity bit.
    function automatic logic is_active_edge(input logic cur_level, input logic rise_sel);
        return cur_level != rise_sel;
    endfunction

endpackage

// File: rtl/ptmr_prescaler.sv
module ptmr_prescaler #(
    parameter int PRESCALE = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic src_en,
    input  logic restart,
    output logic tick
);
    localparam int PW = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
    localparam logic [PW-1:0] LAST = PW'(PRESCALE - 1);

    logic [PW-1:0] div_q;

    assign tick = run && src_en && (div_q == LAST);

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            div_q <= '0;
        end else if (run && src_en) begin
            div_q <= (div_q == LAST) ? '0 : div_q + PW'(1);
        end
    end

    AST_PRESC_FROZEN: assert property (@(posedge clk) disable iff (rst)
        (!run && !restart) |=> $stable(div_q)) else $error("prescaler moved while halted"); // R11

    AST_PRESC_RESTART: assert property (@(posedge clk) disable iff (rst)
        restart |=> (div_q == '0)) else $error("prescaler not restarted"); // R2

endmodule

// File: rtl/ptmr_down_counter.sv
module ptmr_down_counter #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic [CNT_W-1:0] reload_val,
    output logic [CNT_W-1:0] cnt,
    output logic             underflow
);
    logic [CNT_W-1:0] cnt_q;

    assign cnt       = cnt_q;
    assign underflow = tick && (cnt_q == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '1;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (tick) begin
            cnt_q <= (cnt_q == '0) ? reload_val : cnt_q - CNT_W'(1);
        end
    end

    AST_DEC_BY_ONE: assert property (@(posedge clk) disable iff (rst)
        (tick && !load && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - CNT_W'(1))) else $error("bad decrement"); // R2

    AST_RELOAD_AT_UF: assert property (@(posedge clk) disable iff (rst)
        (underflow && !load) |=> (cnt_q == $past(reload_val))) else $error("bad reload"); // R4

    AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (rst)
        (!tick && !load) |=> $stable(cnt_q)) else $error("counter moved without tick"); // R11

endmodule

// File: rtl/ptmr_pulse_gen.sv
module ptmr_pulse_gen
    import ptmr_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic init,
    input  logic init_rise_sel,
    input  logic pulse_mode,
    input  logic rise_sel,
    input  logic underflow,
    output logic pulse,
    output logic edge_evt
);
    logic pulse_q;
    logic toggle;

    assign pulse    = pulse_q;
    assign toggle   = underflow && pulse_mode && !init;
    assign edge_evt = toggle && is_active_edge(pulse_q, rise_sel);

    always_ff @(posedge clk) begin
        if (rst) begin
            pulse_q <= 1'b0;
        end else if (init) begin
            pulse_q <= start_level(init_rise_sel);
        end else if (toggle) begin
            pulse_q <= !pulse_q;
        end
    end

    AST_PULSE_TOGGLE: assert property (@(posedge clk) disable iff (rst)
        toggle |=> (pulse_q != $past(pulse_q))) else $error("pulse did not invert"); // R6

    AST_PULSE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!init && !(underflow && pulse_mode)) |=> $stable(pulse_q)) else $error("pulse moved"); // R6

    AST_PULSE_START: assert property (@(posedge clk) disable iff (rst)
        init |=> (pulse_q == !$past(init_rise_sel))) else $error("bad start level"); // R7

endmodule

// File: rtl/pulse_timer.sv
module pulse_timer
    import ptmr_pkg::*;
#(
    parameter int CNT_W    = 8,
    parameter int PRESCALE = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             slow_sel_i,
    input  logic             sub_tick_i,
    input  logic             wr_en_i,
    input  logic [1:0]       wr_addr_i,
    input  logic [CNT_W-1:0] wr_data_i,
    output logic [CNT_W-1:0] count_o,
    output logic             pulse_o,
    output logic             uf_flag_o,
    output logic             edge_flag_o,
    output logic             uf_irq_o,
    output logic             edge_irq_o
);
    ctrl_t            ctrl_q;
    ctrl_t            ctrl_new;
    logic [CNT_W-1:0] reload_q;
    logic             uf_flag_q;
    logic             edge_flag_q;
    addr_e            waddr;
    logic             wr_ctrl, wr_reload, wr_flags;
    logic             run, restart, src_en, in_pulse, enter_pulse, load_now;
    logic             tick, underflow, edge_evt;

    assign waddr     = addr_e'(wr_addr_i);
    assign wr_ctrl   = wr_en_i && (waddr == ADDR_CTRL);
    assign wr_reload = wr_en_i && (waddr == ADDR_RELOAD);
    assign wr_flags  = wr_en_i && (waddr == ADDR_FLAGS);
    assign ctrl_new  = ctrl_t'(wr_data_i[CTRL_W-1:0]);

    assign run         = !ctrl_q.halt;
    assign restart     = wr_ctrl && ctrl_q.halt && !ctrl_new.halt;
    assign src_en      = slow_sel_i ? sub_tick_i : 1'b1;
    assign in_pulse    = (ctrl_q.mode == MODE_PULSE);
    assign enter_pulse = wr_ctrl && (ctrl_new.mode == MODE_PULSE) && !in_pulse;
    assign load_now    = wr_reload && ctrl_q.halt;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q   <= '0;
            reload_q <= '1;
        end else begin
            if (wr_ctrl)   ctrl_q   <= ctrl_new;
            if (wr_reload) reload_q <= wr_data_i;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            uf_flag_q   <= 1'b0;
            edge_flag_q <= 1'b0;
        end else begin
            if (underflow)                      uf_flag_q   <= 1'b1;
            else if (wr_flags && !wr_data_i[0]) uf_flag_q   <= 1'b0;
            if (edge_evt)                       edge_flag_q <= 1'b1;
            else if (wr_flags && !wr_data_i[1]) edge_flag_q <= 1'b0;
        end
    end

    ptmr_prescaler #(.PRESCALE(PRESCALE)) u_presc (
        .clk     (clk),
        .rst     (rst),
        .run     (run),
        .src_en  (src_en),
        .restart (restart),
        .tick    (tick)
    );

    ptmr_down_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk        (clk),
        .rst        (rst),
        .tick       (tick),
        .load       (load_now),
        .load_val   (wr_data_i),
        .reload_val (reload_q),
        .cnt        (count_o),
        .underflow  (underflow)
    );

    ptmr_pulse_gen u_pulse (
        .clk           (clk),
        .rst           (rst),
        .init          (enter_pulse),
        .init_rise_sel (ctrl_new.rise_sel),
        .pulse_mode    (in_pulse),
        .rise_sel      (ctrl_q.rise_sel),
        .underflow     (underflow),
        .pulse         (pulse_o),
        .edge_evt      (edge_evt)
    );

    assign uf_flag_o   = uf_flag_q;
    assign edge_flag_o = edge_flag_q;
    assign uf_irq_o    = uf_flag_q && ctrl_q.uf_irq_en;
    assign edge_irq_o  = edge_flag_q && ctrl_q.edge_irq_en;

    AST_UF_SETS_FLAG: assert property (@(posedge clk) disable iff (rst)
        underflow |=> uf_flag_o) else $error("underflow flag not set"); // R8

    AST_EDGE_SETS_FLAG: assert property (@(posedge clk) disable iff (rst)
        edge_evt |=> edge_flag_o) else $error("edge flag not set"); // R9

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
        (uf_flag_q && !(wr_flags && !wr_data_i[0])) |=> uf_flag_q) else $error("flag dropped"); // R10

    AST_EDGE_ONLY_PULSE: assert property (@(posedge clk) disable iff (rst)
        (!in_pulse && !edge_flag_q && !wr_ctrl) |=> !edge_flag_q) else $error("edge flag in timer mode"); // R9

endmodule

// File: tb/test_pulse_timer.sv
module test_pulse_timer;
    localparam int W  = 8;
    localparam int PS = 4;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         slow_sel = 1'b0;
    logic         sub_tick = 1'b0;
    logic         wr_en = 1'b0;
    logic [1:0]   wr_addr = 2'd0;
    logic [W-1:0] wr_data = '0;
    logic [W-1:0] count;
    logic         pulse, uf_flag, edge_flag, uf_irq, edge_irq;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    pulse_timer #(.CNT_W(W), .PRESCALE(PS)) i_pulse_timer (
        .clk         (clk),
        .rst         (rst),
        .slow_sel_i  (slow_sel),
        .sub_tick_i  (sub_tick),
        .wr_en_i     (wr_en),
        .wr_addr_i   (wr_addr),
        .wr_data_i   (wr_data),
        .count_o     (count),
        .pulse_o     (pulse),
        .uf_flag_o   (uf_flag),
        .edge_flag_o (edge_flag),
        .uf_irq_o    (uf_irq),
        .edge_irq_o  (edge_irq)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic logic [W-1:0] ctrl_byte(input logic halt, input logic pm,
                                               input logic rs, input logic ue, input logic ee);
        return {2'b00, ee, ue, rs, 1'b0, pm, halt};
    endfunction

    task automatic wr(input logic [1:0] a, input logic [W-1:0] d);
        wr_addr = a;
        wr_data = d;
        wr_en   = 1'b1;
        @(posedge clk);
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    // Halted setup; the final write releases the halt (cycle index 0).
    task automatic setup(input int lv, input logic rs, input logic pm,
                         input logic ue, input logic ee);
        sub_tick = 1'b0;
        wr(2'd1, ctrl_byte(1'b1, 1'b0, rs, 1'b0, 1'b0));
        wr(2'd0, W'(lv));
        check("R5 load while halted", int'(count), lv);
        wr(2'd1, ctrl_byte(1'b1, 1'b1, rs, 1'b0, 1'b0));
        check("R7 start level", int'(pulse), int'(!rs));
        wr(2'd2, 8'h00);
        check("R10 clear uf", int'(uf_flag), 0);
        check("R10 clear edge", int'(edge_flag), 0);
        wr(2'd1, ctrl_byte(1'b0, pm, rs, ue, ee));
    endtask

    task automatic sweep(input int lv, input logic rs, input logic pm,
                         input logic ue, input logic ee, input logic slow);
        int last;
        slow_sel = slow;
        setup(lv, rs, pm, ue, ee);
        last = (lv + 1) * PS * 2 * (slow ? 2 : 1) + 5;
        for (int m = 1; m <= last; m++) begin
            int en_cnt, k, n, exp_cnt, exp_pulse, exp_uf, exp_ef;
            sub_tick = slow ? logic'(m % 2) : 1'b0;
            step();
            en_cnt    = slow ? (m + 1) / 2 : m;
            k         = en_cnt / PS;
            n         = k / (lv + 1);
            exp_cnt   = lv - (k % (lv + 1));
            exp_pulse = pm ? (int'(!rs) ^ (n % 2)) : int'(!rs);
            exp_uf    = (n >= 1) ? 1 : 0;
            exp_ef    = (pm && n >= 1) ? 1 : 0;
            if (slow) check("R3 count", int'(count), exp_cnt);
            else      check("R2 R4 count", int'(count), exp_cnt);
            check("R6 pulse", int'(pulse), exp_pulse);
            check("R8 uf flag", int'(uf_flag), exp_uf);
            check("R8 uf irq", int'(uf_irq), exp_uf & int'(ue));
            check("R9 edge flag", int'(edge_flag), exp_ef);
            check("R9 edge irq", int'(edge_irq), exp_ef & int'(ee));
        end
        sub_tick = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL R1 watchdog actual=timeout expected=finish");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        check("R1 count", int'(count), 255);
        check("R1 pulse", int'(pulse), 0);
        check("R1 uf flag", int'(uf_flag), 0);
        check("R1 edge flag", int'(edge_flag), 0);
        check("R1 irqs", int'({uf_irq, edge_irq}), 0);
        repeat (PS - 1) step();
        check("R1 auto start before tick", int'(count), 255);
        step();
        check("R1 auto start", int'(count), 254);

        sweep(0,   1'b0, 1'b1, 1'b1, 1'b1, 1'b0);
        sweep(1,   1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
        sweep(3,   1'b0, 1'b0, 1'b1, 1'b1, 1'b0);
        sweep(255, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0);

        // R10: flags survive writes of 1 and clear bit by bit
        wr(2'd1, ctrl_byte(1'b1, 1'b1, 1'b1, 1'b1, 1'b0));
        check("R10 uf still set", int'(uf_flag), 1);
        check("R10 edge still set", int'(edge_flag), 1);
        wr(2'd2, 8'h03);
        check("R10 ones keep uf", int'(uf_flag), 1);
        check("R10 ones keep edge", int'(edge_flag), 1);
        wr(2'd2, 8'h02);
        check("R10 clear uf only", int'(uf_flag), 0);
        check("R10 edge kept", int'(edge_flag), 1);
        wr(2'd2, 8'h00);
        check("R10 clear edge", int'(edge_flag), 0);

        // R3: low-speed source with strobe
        sweep(2, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1);
        begin
            int hold_val;
            hold_val = int'(count);
            sub_tick = 1'b0;
            repeat (30) step();
            check("R3 no strobe no count", int'(count), hold_val);
        end
        slow_sel = 1'b0;

        // R5: reload write while running leaves counter alone
        setup(200, 1'b0, 1'b1, 1'b0, 1'b0);
        repeat (8) step();
        wr(2'd0, 8'd3);
        check("R5 running write ignored", int'(count), 198);
        repeat (3) step();
        check("R5 count continues", int'(count), 197);

        // R11: halt freezes state; R2: prescaler restarts on release
        wr(2'd1, ctrl_byte(1'b1, 1'b1, 1'b0, 1'b0, 1'b0));
        repeat (40) step();
        check("R11 count frozen", int'(count), 197);
        check("R11 pulse frozen", int'(pulse), 1);
        wr(2'd1, ctrl_byte(1'b0, 1'b1, 1'b0, 1'b0, 1'b0));
        repeat (PS - 1) step();
        check("R2 restart no early tick", int'(count), 197);
        step();
        check("R2 restart tick", int'(count), 196);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule